// File: doc/BRIEF.md
# Complementary PWM Dead-Time Gate Controller

This block turns a single PWM request into a pair of complementary gate-drive enables for a half bridge: one for the upper (high-side) switch and one for the lower (low-side) switch. A high PWM level selects the upper switch and a low level selects the lower one. On every change of side, the active output is dropped first. Both outputs then stay low for a programmable number of clock cycles before the other side turns on. The two outputs are never high together in any state.

Three synchronous supply-good flags gate the outputs. The control side gates both outputs, the upper driver gates the high-side output and the lower driver gates the low-side output. Each flag has its own start-up hold timer. When a flag returns high, that timer keeps the outputs it governs low for a programmable number of cycles. A disable input forces both outputs low. The PWM and disable pins pass through a two-flop synchroniser before use. Dead time and hold time are given in clock cycles and are captured from their configuration inputs each time a countdown is loaded.

Top module: `halfbridge_gap_ctrl`

## Requirements
- R1: While reset is high, both outputs are low. Reset arms the start-up hold of all three supply domains.
- R2: With G the value on `gap_cycles`, a PWM level change at the pin drops the active output on the 3rd rising clock edge after the change. The opposite output rises on the (G+4)th edge. Both outputs are low for G+1 cycles in between. PWM high selects `hs_drive` and PWM low selects `ls_drive`.
- R3: `hs_drive` and `ls_drive` are never high in the same cycle.
- R4: When an output becomes allowed again after disable or lockout, it does not turn on at once. The full gap applies first. After `disable_in` falls at the pin, the selected output rises on the (G+3)th rising edge.
- R5: With `gap_cycles` = 0, a side change leaves exactly one cycle with both outputs low.
- R6: After `disable_in` rises at the pin, both outputs are low from the 3rd rising edge on, whatever PWM does.
- R7: When `in_supply_ok` is low, both outputs are low from the 2nd rising edge after it falls. Toggling `disable_in` during that time changes nothing.
- R8: With H the value on `hold_cycles`, a supply flag that returns high keeps the outputs it governs low for the start-up hold. If the selected side is otherwise free, it rises on the (H+G+3)th rising edge after the flag rises. The same holds for the first enable after reset is released.
- R9: The lockout of one driver domain does not affect the other output. With `ls_supply_ok` low, `hs_drive` keeps following PWM, and the reverse also holds.
- R10: A PWM level that lasts no longer than the dead time never turns its side on. The gap count restarts whenever the requested side changes. Both outputs stay low until one level has held for G+1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwm_in | input | 1 | Asynchronous PWM request (high selects the upper switch) |
| disable_in | input | 1 | Asynchronous force-off request |
| gap_cycles | input | GAP_W | Dead-time setting in clock cycles |
| hold_cycles | input | HOLD_W | Start-up hold setting in clock cycles |
| in_supply_ok | input | 1 | Control-side supply good (gates both outputs) |
| hs_supply_ok | input | 1 | Upper-driver supply good |
| ls_supply_ok | input | 1 | Lower-driver supply good |
| hs_drive | output | 1 | High-side gate enable |
| ls_drive | output | 1 | Low-side gate enable |

## Verification
The dead-time countdown and the gating logic (disable, lockout, start-up hold) can both act on the same cycle. The bench provokes this in three ways: it changes PWM while disable is held, it releases disable once the new level has settled, and it brings a supply back while the other side is requested. Each case is judged by the cycle in which the output rises, which must still include the full gap. A second collision occurs when a PWM edge lands inside a running gap. The bench sends a pulse shorter than the gap and expects the count to restart, with the short-lived side never asserting.

// File: rtl/hbgap_pkg.sv
package hbgap_pkg;
  typedef enum logic [1:0] {
    SIDE_OFF = 2'd0,
    SIDE_HI  = 2'd1,
    SIDE_LO  = 2'd2
  } side_e;

  localparam int NUM_DOM = 3;
  localparam int DOM_IN  = 0;
  localparam int DOM_HI  = 1;
  localparam int DOM_LO  = 2;
endpackage

// File: rtl/hbgap_sync.sv
module hbgap_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[s] <= '0;
        else     stg[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[s] <= '0;
        else     stg[s] <= stg[s-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/hbgap_hold.sv
module hbgap_hold #(
  parameter int HOLD_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              supply_ok,
  input  logic [HOLD_W-1:0] hold_cycles,
  output logic              ready
);
  logic              armed;
  logic [HOLD_W-1:0] cnt;

  // Armed until the supply is seen good; then count the hold down.
  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b1;
      cnt   <= '0;
      ready <= 1'b0;
    end else if (!supply_ok) begin
      armed <= 1'b1;
      cnt   <= '0;
      ready <= 1'b0;
    end else if (armed) begin
      armed <= 1'b0;
      cnt   <= hold_cycles;
      ready <= 1'b0;
    end else begin
      if (cnt != '0) cnt <= cnt - 1'b1;
      ready <= (cnt == '0);
    end
  end

  assert_hold_drop_R8: assert property (@(posedge clk) disable iff (rst)
    !supply_ok |=> !ready);
  assert_hold_arm_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(supply_ok) |=> !ready);
endmodule

// File: rtl/hbgap_core.sv
module hbgap_core
  import hbgap_pkg::*;
#(
  parameter int GAP_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             want_hi,
  input  logic             en_hi,
  input  logic             en_lo,
  input  logic [GAP_W-1:0] gap_cycles,
  output logic             hs_q,
  output logic             ls_q
);
  side_e            side;
  side_e            last_req;
  side_e            req;
  logic             req_en;
  logic [GAP_W-1:0] cnt;

  assign req    = want_hi ? SIDE_HI : SIDE_LO;
  assign req_en = want_hi ? en_hi : en_lo;

  always_ff @(posedge clk) begin
    if (rst) begin
      side     <= SIDE_OFF;
      last_req <= SIDE_LO;
      cnt      <= '0;
      hs_q     <= 1'b0;
      ls_q     <= 1'b0;
    end else begin
      case (side)
        SIDE_OFF: begin
          if (req != last_req || !req_en) begin
            // request moved or blocked: restart the gap
            last_req <= req;
            cnt      <= gap_cycles;
          end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
          end else begin
            side <= req;
            hs_q <= (req == SIDE_HI);
            ls_q <= (req == SIDE_LO);
          end
        end
        default: begin
          if (req != side || !req_en) begin
            side     <= SIDE_OFF;
            hs_q     <= 1'b0;
            ls_q     <= 1'b0;
            last_req <= req;
            cnt      <= gap_cycles;
          end
        end
      endcase
    end
  end

  assert_no_overlap_R3: assert property (@(posedge clk) disable iff (rst)
    !(hs_q && ls_q));
  assert_gap_before_hi_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(hs_q) |-> !$past(ls_q));
  assert_gap_before_lo_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(ls_q) |-> !$past(hs_q));
  assert_blocked_hi_R9: assert property (@(posedge clk) disable iff (rst)
    !en_hi |=> !hs_q);
  assert_blocked_lo_R9: assert property (@(posedge clk) disable iff (rst)
    !en_lo |=> !ls_q);
endmodule

// File: rtl/halfbridge_gap_ctrl.sv
module halfbridge_gap_ctrl
  import hbgap_pkg::*;
#(
  parameter int GAP_W       = 8,
  parameter int HOLD_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pwm_in,
  input  logic              disable_in,
  input  logic [GAP_W-1:0]  gap_cycles,
  input  logic [HOLD_W-1:0] hold_cycles,
  input  logic              in_supply_ok,
  input  logic              hs_supply_ok,
  input  logic              ls_supply_ok,
  output logic              hs_drive,
  output logic              ls_drive
);
  localparam int SYNC_W = 2;

  logic [SYNC_W-1:0]  pin_sync;
  logic               pwm_s;
  logic               dis_s;
  logic [NUM_DOM-1:0] ok_vec;
  logic [NUM_DOM-1:0] ready_vec;
  logic               en_hi;
  logic               en_lo;

  hbgap_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({disable_in, pwm_in}),
    .q   (pin_sync)
  );
  assign pwm_s = pin_sync[0];
  assign dis_s = pin_sync[1];

  assign ok_vec[DOM_IN] = in_supply_ok;
  assign ok_vec[DOM_HI] = hs_supply_ok;
  assign ok_vec[DOM_LO] = ls_supply_ok;

  for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
    hbgap_hold #(.HOLD_W(HOLD_W)) u_hold (
      .clk         (clk),
      .rst         (rst),
      .supply_ok   (ok_vec[d]),
      .hold_cycles (hold_cycles),
      .ready       (ready_vec[d])
    );
  end

  assign en_hi = ready_vec[DOM_IN] & ready_vec[DOM_HI] & ~dis_s;
  assign en_lo = ready_vec[DOM_IN] & ready_vec[DOM_LO] & ~dis_s;

  hbgap_core #(.GAP_W(GAP_W)) u_core (
    .clk        (clk),
    .rst        (rst),
    .want_hi    (pwm_s),
    .en_hi      (en_hi),
    .en_lo      (en_lo),
    .gap_cycles (gap_cycles),
    .hs_q       (hs_drive),
    .ls_q       (ls_drive)
  );

  assert_input_lockout_R7: assert property (@(posedge clk) disable iff (rst)
    !ready_vec[DOM_IN] |=> (!hs_drive && !ls_drive));
  assert_disable_off_R6: assert property (@(posedge clk) disable iff (rst)
    dis_s |=> (!hs_drive && !ls_drive));
  assert_reset_low_R1: assert property (@(posedge clk)
    rst |=> (!hs_drive && !ls_drive));
endmodule

// File: tb/test_halfbridge_gap_ctrl.sv
module test_halfbridge_gap_ctrl;
  localparam int GAP_W  = 8;
  localparam int HOLD_W = 12;
  localparam int G = 3;
  localparam int H = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pwm = 1'b0;
  logic dis = 1'b0;
  logic in_ok = 1'b1;
  logic hs_ok = 1'b1;
  logic ls_ok = 1'b1;
  logic [GAP_W-1:0]  gap  = GAP_W'(G);
  logic [HOLD_W-1:0] hold = HOLD_W'(H);
  logic hs, ls;

  halfbridge_gap_ctrl #(.GAP_W(GAP_W), .HOLD_W(HOLD_W)) i_halfbridge_gap_ctrl (
    .clk(clk), .rst(rst), .pwm_in(pwm), .disable_in(dis),
    .gap_cycles(gap), .hold_cycles(hold),
    .in_supply_ok(in_ok), .hs_supply_ok(hs_ok), .ls_supply_ok(ls_ok),
    .hs_drive(hs), .ls_drive(ls)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int    at;
    logic  hs;
    logic  ls;
    string tag;
  } exp_t;
  exp_t sb[$];

  int checks = 0;
  int fails  = 0;
  bit overlap_seen = 1'b0;
  bit done = 1'b0;

  // driver side of the scoreboard
  task automatic expect_at(int rel, logic h, logic l, string tag);
    exp_t e;
    e.at = cyc + rel; e.hs = h; e.ls = l; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic expect_span(int from, int to, logic h, logic l, string tag);
    for (int i = from; i <= to; i++) expect_at(i, h, l, tag);
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drain();
    while (sb.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // monitor side
  always @(negedge clk) begin
    if (!rst && hs && ls) overlap_seen = 1'b1;
    while (sb.size() > 0 && sb[0].at <= cyc) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (e.at < cyc) begin
        fails++;
        $display("FAIL %s: cycle %0d missed (actual cycle %0d, expected %0d)", e.tag, e.at, cyc, e.at);
      end else if (hs !== e.hs || ls !== e.ls) begin
        fails++;
        $display("FAIL %s: cycle %0d hs/ls actual %b%b expected %b%b", e.tag, cyc, hs, ls, e.hs, e.ls);
      end
    end
  end

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    step(3);
    checks++;
    if (hs !== 1'b0 || ls !== 1'b0) begin
      fails++;
      $display("FAIL R1: in reset hs/ls actual %b%b expected 00", hs, ls);
    end
    // R8 / R1: start-up hold after reset, then the gap
    rst = 1'b0;
    expect_span(1, H + G + 2, 1'b0, 1'b0, "R8 reset hold");
    expect_at(H + G + 3, 1'b0, 1'b1, "R8 reset hold");
    drain(); step(2);

    // R2: low to high
    pwm = 1'b1;
    expect_at(2, 1'b0, 1'b1, "R2 rise");
    expect_span(3, G + 3, 1'b0, 1'b0, "R2 rise gap");
    expect_at(G + 4, 1'b1, 1'b0, "R2 rise");
    drain(); step(2);

    // R2: high to low
    pwm = 1'b0;
    expect_at(2, 1'b1, 1'b0, "R2 fall");
    expect_span(3, G + 3, 1'b0, 1'b0, "R2 fall gap");
    expect_at(G + 4, 1'b0, 1'b1, "R2 fall");
    drain(); step(2);

    // R5: zero gap gives one both-low cycle
    gap = '0;
    step(1);
    pwm = 1'b1;
    expect_at(2, 1'b0, 1'b1, "R5");
    expect_at(3, 1'b0, 1'b0, "R5");
    expect_at(4, 1'b1, 1'b0, "R5");
    drain();
    pwm = 1'b0;
    expect_at(2, 1'b1, 1'b0, "R5");
    expect_at(3, 1'b0, 1'b0, "R5");
    expect_at(4, 1'b0, 1'b1, "R5");
    drain();

    // R10: pulse shorter than gap of 5 is cancelled
    gap = GAP_W'(5);
    step(1);
    pwm = 1'b1;
    expect_at(2, 1'b0, 1'b1, "R10");
    expect_span(3, 10, 1'b0, 1'b0, "R10 cancel");
    expect_at(11, 1'b0, 1'b1, "R10");
    step(2);
    pwm = 1'b0;
    drain();
    gap = GAP_W'(G);
    step(2);

    // R6: disable forces off, PWM moves while disabled
    dis = 1'b1;
    expect_at(2, 1'b0, 1'b1, "R6");
    expect_span(3, 12, 1'b0, 1'b0, "R6 disabled");
    step(3);
    pwm = 1'b1;
    drain();
    // R4: release disable, gap applies to the first transition
    dis = 1'b0;
    expect_span(1, G + 2, 1'b0, 1'b0, "R4 gap");
    expect_at(G + 3, 1'b1, 1'b0, "R4");
    drain(); step(2);

    // R7: input-side lockout, disable has no effect
    in_ok = 1'b0;
    expect_at(1, 1'b1, 1'b0, "R7");
    expect_span(2, 9, 1'b0, 1'b0, "R7 lockout");
    step(2); dis = 1'b1;
    step(2); dis = 1'b0;
    drain(); step(2);
    // R8: supply back, hold then gap
    in_ok = 1'b1;
    expect_span(1, H + G + 2, 1'b0, 1'b0, "R8 hold");
    expect_at(H + G + 3, 1'b1, 1'b0, "R8");
    drain(); step(2);

    // R9: lower-driver lockout leaves upper untouched
    ls_ok = 1'b0;
    expect_span(1, 8, 1'b1, 1'b0, "R9 hs kept");
    drain();
    pwm = 1'b0;
    expect_at(2, 1'b1, 1'b0, "R9");
    expect_span(3, 12, 1'b0, 1'b0, "R9 ls blocked");
    drain();
    ls_ok = 1'b1;
    expect_span(1, H + G + 2, 1'b0, 1'b0, "R9 hold");
    expect_at(H + G + 3, 1'b0, 1'b1, "R9");
    drain(); step(2);

    // R3: no overlap across the run
    checks++;
    if (overlap_seen) begin
      fails++;
      $display("FAIL R3: overlap actual seen expected none");
    end
    done = 1'b1;
    report();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected completion");
      report();
      $finish;
    end
  end
endmodule